// File: doc/BRIEF.md
# DRAM Mode-Register Command Sequencer

This block sits inside a DDR memory controller and gives software direct control of the DRAM command bus. Software raises a command-mode request and polls an acknowledge status. Once the status is up, software can do one of two things. It can start a mode-register burst, in which the sequencer writes the stored mode-register values to every enabled rank in a fixed register order. Or it can place one raw command on the bus, built from a rank index, a command code, a bank and an address.

A mode-register burst walks the registers in the order MR2, MR3, MR1, MR0. Within each register it visits ranks 0 to 3. A 4-bit rank-enable mask removes ranks from the walk. Issued commands are separated by a programmable gap filled with idle cycles. A done flag reports when the burst has finished. Requests that arrive outside command mode, or while a burst is running, have no effect.

Top module: `mrs_cmd_seq`

## Requirements
- R1: After `cmd_mode_i` has been sampled high on two consecutive rising edges, `status_cmd_o` reads 1 from the second of those edges onward.
- R2: When `cmd_mode_i` is sampled low and no burst is running, `status_cmd_o` reads 0 after that edge. If a burst is running, `status_cmd_o` stays 1 until the edge that raises `mrs_done_o`, and reads 0 from the next edge onward.
- R3: A burst visits slots in the order MR2 ranks 0..3, MR3 ranks 0..3, MR1 ranks 0..3, MR0 ranks 0..3.
- R4: A slot whose rank bit in `cs_en_i` is 0 puts nothing on the bus and takes no cycles. The next enabled slot follows at the normal spacing.
- R5: Each mode-register command drives the following for one cycle:
  - `dram_cs_n_o` low only at its rank;
  - `dram_ras_n_o`, `dram_cas_n_o` and `dram_we_n_o` all at 0;
  - `dram_ba_o` equal to the register number;
  - `dram_addr_o` equal to `mr_vals_i[(reg*4+rank)*16 +: 16]`.
- R6: Two consecutive mode-register commands appear max(`tmrd_i`, 2) cycles apart. Every cycle with no command shows the idle pattern: all `cs_n` high, `ras_n`, `cas_n` and `we_n` high, bank 0, address 0.
- R7: With `mrs_req_i` accepted at edge E0, the first command appears after edge E0+1.
- R8: `mrs_done_o` rises one cycle after the last command of the burst. With an empty mask, it rises after edge E0+1. It clears on the edge that accepts a new `mrs_req_i`.
- R9: A `cmd_req_i` accepted at an edge drives one command after that edge. In that command, `dram_cs_n_o` is low only at rank `cmd_cs_i`, {`ras_n`, `cas_n`, `we_n`} equals `cmd_cmd_i`, `dram_ba_o` equals `cmd_ba_i`, and `dram_addr_o` equals `cmd_a_i`. The bus is idle in the following cycle.
- R10: `cmd_req_i` and `mrs_req_i` are ignored while `status_cmd_o` is 0 or a burst is running. When both arrive in the same cycle, only the burst starts.
- R11: At most one `dram_cs_n_o` bit is low in any cycle.
- R12: After reset, `status_cmd_o` and `mrs_done_o` are 0 and the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_mode_i | input | 1 | Level request to enter command mode |
| status_cmd_o | output | 1 | Command mode acknowledged |
| cs_en_i | input | 4 | Rank enable mask for mode-register bursts |
| tmrd_i | input | 4 | Gap between mode-register commands, in cycles (minimum 2 applied) |
| mr_vals_i | input | 256 | Sixteen 16-bit mode-register values, index reg*4+rank |
| mrs_req_i | input | 1 | Start a mode-register burst |
| mrs_done_o | output | 1 | Burst finished |
| cmd_req_i | input | 1 | Issue one raw command |
| cmd_cs_i | input | 2 | Raw command rank index |
| cmd_cmd_i | input | 3 | Raw command {ras_n, cas_n, we_n} |
| cmd_ba_i | input | 3 | Raw command bank |
| cmd_a_i | input | 16 | Raw command address |
| dram_cs_n_o | output | 4 | Per-rank chip select, active low |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_we_n_o | output | 1 | Write enable, active low |
| dram_ba_o | output | 3 | Bank address |
| dram_addr_o | output | 16 | Address lines |

## Verification
A wrong slot pointer or a corrupt register-order decode shows up at the first misplaced command. That command carries a bank number or address value that does not match the expected slot, and it is visible in the very cycle it appears. A gap counter that is off by one shifts every later command by a cycle, and the cycle-stamped command log exposes this at the second command. A faulty busy or acknowledge state has two visible effects: a raw request leaks onto the bus during a burst or outside command mode, or the status bit drops before the done flag rises. Either effect is visible within one cycle of the offending edge.

// File: rtl/mrs_seq_pkg.sv
package mrs_seq_pkg;

    localparam int RANKS    = 4;
    localparam int NUM_MR   = 4;
    localparam int RANK_W   = $clog2(RANKS);
    localparam int SLOTS    = RANKS * NUM_MR;
    localparam int SLOT_W   = $clog2(SLOTS) + 1;
    localparam int MR_W     = 16;
    localparam int BA_W     = 3;
    localparam int TMRD_W   = 4;
    localparam int MIN_GAP  = 2;

    typedef struct packed {
        logic [RANKS-1:0] cs_n;
        logic             ras_n;
        logic             cas_n;
        logic             we_n;
        logic [BA_W-1:0]  ba;
        logic [MR_W-1:0]  addr;
    } dram_cmd_t;

    localparam dram_cmd_t IDLE_CMD = '{cs_n: '1, ras_n: 1'b1, cas_n: 1'b1,
                                       we_n: 1'b1, ba: '0, addr: '0};

    typedef enum logic [1:0] {W_IDLE, W_RUN, W_FINISH} walk_state_t;

    // Register visited in each group of the burst: MR2, MR3, MR1, MR0.
    function automatic logic [1:0] group_reg(input logic [1:0] grp);
        case (grp)
            2'd0:    return 2'd2;
            2'd1:    return 2'd3;
            2'd2:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    // First slot at or after 'from' whose rank is enabled; SLOTS if none.
    function automatic logic [SLOT_W-1:0] next_slot(input logic [RANKS-1:0] en,
                                                    input logic [SLOT_W-1:0] from);
        logic [SLOT_W-1:0] found;
        found = SLOT_W'(SLOTS);
        for (int p = SLOTS - 1; p >= 0; p--) begin
            if (SLOT_W'(p) >= from && en[p % RANKS])
                found = SLOT_W'(p);
        end
        return found;
    endfunction

endpackage

// File: rtl/mode_ack.sv
module mode_ack (
    input  logic clk,
    input  logic rst,
    input  logic mode_req,
    input  logic hold,
    output logic ack
);
    logic req_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_seen <= 1'b0;
            ack      <= 1'b0;
        end else begin
            req_seen <= mode_req;
            ack      <= hold ? 1'b1 : (req_seen & mode_req);
        end
    end
endmodule

// File: rtl/mrs_slot_walker.sv
module mrs_slot_walker
    import mrs_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [RANKS-1:0]   en,
    input  logic [TMRD_W-1:0]  gap,
    output logic               issue,
    output logic [1:0]         issue_reg,
    output logic [RANK_W-1:0]  issue_rank,
    output logic               busy,
    output logic               done
);
    walk_state_t        state;
    logic [SLOT_W-1:0]  pos;
    logic [TMRD_W-1:0]  cnt;
    logic [TMRD_W-1:0]  gap_eff;
    logic [SLOT_W-1:0]  first_pos;
    logic [SLOT_W-1:0]  after_pos;

    assign gap_eff    = (gap < TMRD_W'(MIN_GAP)) ? TMRD_W'(MIN_GAP) : gap;
    assign first_pos  = next_slot(en, '0);
    assign after_pos  = next_slot(en, pos + 1'b1);
    assign issue      = (state == W_RUN) && (cnt == '0);
    assign issue_reg  = group_reg(pos[RANK_W +: 2]);
    assign issue_rank = pos[RANK_W-1:0];
    assign busy       = (state != W_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= W_IDLE;
            pos   <= '0;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            case (state)
                W_IDLE: begin
                    if (start) begin
                        done  <= 1'b0;
                        pos   <= first_pos;
                        cnt   <= '0;
                        state <= (first_pos == SLOT_W'(SLOTS)) ? W_FINISH : W_RUN;
                    end
                end
                W_RUN: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (after_pos == SLOT_W'(SLOTS)) begin
                        state <= W_FINISH;
                    end else begin
                        pos <= after_pos;
                        cnt <= gap_eff - 1'b1;
                    end
                end
                default: begin
                    done  <= 1'b1;
                    state <= W_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/cmd_bus_drive.sv
module cmd_bus_drive
    import mrs_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mrs_go,
    input  logic [1:0]         mrs_reg,
    input  logic [RANK_W-1:0]  mrs_rank,
    input  logic [MR_W-1:0]    mrs_val,
    input  logic               raw_go,
    input  logic [RANK_W-1:0]  raw_rank,
    input  logic [2:0]         raw_code,
    input  logic [BA_W-1:0]    raw_ba,
    input  logic [MR_W-1:0]    raw_addr,
    output dram_cmd_t          bus
);
    dram_cmd_t nxt;

    always_comb begin
        nxt = IDLE_CMD;
        if (mrs_go) begin
            nxt.cs_n[mrs_rank] = 1'b0;
            nxt.ras_n          = 1'b0;
            nxt.cas_n          = 1'b0;
            nxt.we_n           = 1'b0;
            nxt.ba             = BA_W'(mrs_reg);
            nxt.addr           = mrs_val;
        end else if (raw_go) begin
            nxt.cs_n[raw_rank] = 1'b0;
            {nxt.ras_n, nxt.cas_n, nxt.we_n} = raw_code;
            nxt.ba             = raw_ba;
            nxt.addr           = raw_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bus <= IDLE_CMD;
        else     bus <= nxt;
    end
endmodule

// File: rtl/mrs_cmd_seq.sv
module mrs_cmd_seq
    import mrs_seq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_mode_i,
    output logic                     status_cmd_o,
    input  logic [RANKS-1:0]         cs_en_i,
    input  logic [TMRD_W-1:0]        tmrd_i,
    input  logic [SLOTS*MR_W-1:0]    mr_vals_i,
    input  logic                     mrs_req_i,
    output logic                     mrs_done_o,
    input  logic                     cmd_req_i,
    input  logic [RANK_W-1:0]        cmd_cs_i,
    input  logic [2:0]               cmd_cmd_i,
    input  logic [BA_W-1:0]          cmd_ba_i,
    input  logic [MR_W-1:0]          cmd_a_i,
    output logic [RANKS-1:0]         dram_cs_n_o,
    output logic                     dram_ras_n_o,
    output logic                     dram_cas_n_o,
    output logic                     dram_we_n_o,
    output logic [BA_W-1:0]          dram_ba_o,
    output logic [MR_W-1:0]          dram_addr_o
);
    logic              busy;
    logic              mrs_accept;
    logic              raw_accept;
    logic              issue;
    logic [1:0]        issue_reg;
    logic [RANK_W-1:0] issue_rank;
    logic [MR_W-1:0]   issue_val;
    dram_cmd_t         bus;

    assign mrs_accept = mrs_req_i & status_cmd_o & ~busy;
    assign raw_accept = cmd_req_i & status_cmd_o & ~busy & ~mrs_req_i;
    assign issue_val  = mr_vals_i[(int'(issue_reg) * RANKS + int'(issue_rank)) * MR_W +: MR_W];

    mode_ack u_ack (
        .clk      (clk),
        .rst      (rst),
        .mode_req (cmd_mode_i),
        .hold     (busy | mrs_accept),
        .ack      (status_cmd_o)
    );

    mrs_slot_walker u_walk (
        .clk        (clk),
        .rst        (rst),
        .start      (mrs_accept),
        .en         (cs_en_i),
        .gap        (tmrd_i),
        .issue      (issue),
        .issue_reg  (issue_reg),
        .issue_rank (issue_rank),
        .busy       (busy),
        .done       (mrs_done_o)
    );

    cmd_bus_drive u_bus (
        .clk      (clk),
        .rst      (rst),
        .mrs_go   (issue),
        .mrs_reg  (issue_reg),
        .mrs_rank (issue_rank),
        .mrs_val  (issue_val),
        .raw_go   (raw_accept),
        .raw_rank (cmd_cs_i),
        .raw_code (cmd_cmd_i),
        .raw_ba   (cmd_ba_i),
        .raw_addr (cmd_a_i),
        .bus      (bus)
    );

    assign dram_cs_n_o  = bus.cs_n;
    assign dram_ras_n_o = bus.ras_n;
    assign dram_cas_n_o = bus.cas_n;
    assign dram_we_n_o  = bus.we_n;
    assign dram_ba_o    = bus.ba;
    assign dram_addr_o  = bus.addr;
endmodule

// File: rtl/mrs_cmd_seq_chk.sv
module mrs_cmd_seq_chk
    import mrs_seq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cmd_mode_i,
    input logic             status_cmd_o,
    input logic             mrs_req_i,
    input logic             mrs_done_o,
    input logic             busy,
    input logic [RANKS-1:0] dram_cs_n_o
);
    p_ack_delay_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(status_cmd_o) |-> $past(cmd_mode_i) && $past(cmd_mode_i, 2));

    p_quiet_outside_mode_r10: assert property (@(posedge clk) disable iff (rst)
        !status_cmd_o |=> &dram_cs_n_o);

    p_done_ends_burst_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(mrs_done_o) |-> !busy && $past(busy));

    p_done_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (mrs_req_i && status_cmd_o && !busy) |=> !mrs_done_o);

    p_single_rank_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~dram_cs_n_o));

    p_mode_held_in_burst_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> status_cmd_o);
endmodule

bind mrs_cmd_seq mrs_cmd_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_mode_i   (cmd_mode_i),
    .status_cmd_o (status_cmd_o),
    .mrs_req_i    (mrs_req_i),
    .mrs_done_o   (mrs_done_o),
    .busy         (busy),
    .dram_cs_n_o  (dram_cs_n_o)
);

// File: tb/test_mrs_cmd_seq.sv
module test_mrs_cmd_seq;
    import mrs_seq_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  cmd_mode_i = 1'b0;
    logic                  status_cmd_o;
    logic [RANKS-1:0]      cs_en_i = '1;
    logic [TMRD_W-1:0]     tmrd_i = 4'd4;
    logic [SLOTS*MR_W-1:0] mr_vals_i;
    logic                  mrs_req_i = 1'b0;
    logic                  mrs_done_o;
    logic                  cmd_req_i = 1'b0;
    logic [RANK_W-1:0]     cmd_cs_i = '0;
    logic [2:0]            cmd_cmd_i = 3'b111;
    logic [BA_W-1:0]       cmd_ba_i = '0;
    logic [MR_W-1:0]       cmd_a_i = '0;
    logic [RANKS-1:0]      dram_cs_n_o;
    logic                  dram_ras_n_o, dram_cas_n_o, dram_we_n_o;
    logic [BA_W-1:0]       dram_ba_o;
    logic [MR_W-1:0]       dram_addr_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mrs_cmd_seq i_mrs_cmd_seq (.*);

    function automatic logic [15:0] mrv(input int r, input int k);
        return {4'(r), 4'(k), 8'((r * 4 + k) * 37) ^ 8'hC3};
    endfunction

    initial begin
        for (int r = 0; r < NUM_MR; r++)
            for (int k = 0; k < RANKS; k++)
                mr_vals_i[(r * RANKS + k) * MR_W +: MR_W] = mrv(r, k);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit bus_idle();
        return (&dram_cs_n_o) && dram_ras_n_o && dram_cas_n_o && dram_we_n_o &&
               dram_ba_o == '0 && dram_addr_o == '0;
    endfunction

    task automatic t_reset();
        check(status_cmd_o == 1'b0, "R12", "status after reset", status_cmd_o, 0);
        check(mrs_done_o == 1'b0, "R12", "done after reset", mrs_done_o, 0);
        check(bus_idle(), "R12", "bus idle after reset", dram_cs_n_o, 4'hF);
    endtask

    task automatic t_enter();
        cmd_mode_i = 1'b1;
        @(negedge clk);
        check(status_cmd_o == 1'b0, "R1", "status one cycle after request", status_cmd_o, 0);
        @(negedge clk);
        check(status_cmd_o == 1'b1, "R1", "status two cycles after request", status_cmd_o, 1);
    endtask

    // Runs one burst; logs every command with its cycle number.
    task automatic t_burst(input logic [3:0] mask, input int tmrd,
                           input bit inject_raw, input bit drop_mode);
        int exp_cyc[16]; int exp_reg[16]; int exp_rank[16]; int n_exp;
        int got_cyc[20]; int got_reg[20]; int got_rank[20]; int got_addr[20]; int n_got;
        int done_cyc; int low_cyc; int gap; int ord[4]; int bad_idle;
        ord = '{2, 3, 1, 0};
        gap = (tmrd < 2) ? 2 : tmrd;
        n_exp = 0; n_got = 0; done_cyc = -1; low_cyc = -1; bad_idle = 0;
        for (int p = 0; p < SLOTS; p++) begin
            if (mask[p % 4]) begin
                exp_cyc[n_exp]  = (n_exp == 0) ? 2 : exp_cyc[n_exp-1] + gap;
                exp_reg[n_exp]  = ord[p / 4];
                exp_rank[n_exp] = p % 4;
                n_exp++;
            end
        end
        cs_en_i   = mask;
        tmrd_i    = 4'(tmrd);
        mrs_req_i = 1'b1;
        for (int c = 1; c <= 90; c++) begin
            @(negedge clk);
            if (c == 1) mrs_req_i = 1'b0;
            if (!(&dram_cs_n_o)) begin
                if (n_got < 20) begin
                    got_cyc[n_got]  = c;
                    got_reg[n_got]  = int'(dram_ba_o);
                    got_addr[n_got] = int'(dram_addr_o);
                    got_rank[n_got] = 0;
                    for (int k = 0; k < RANKS; k++)
                        if (!dram_cs_n_o[k]) got_rank[n_got] = k;
                    if (dram_ras_n_o || dram_cas_n_o || dram_we_n_o) bad_idle++;
                end
                n_got++;
            end else if (!bus_idle()) begin
                bad_idle++;
            end
            if (mrs_done_o && done_cyc < 0) done_cyc = c;
            if (drop_mode && !status_cmd_o && low_cyc < 0) low_cyc = c;
            if (c == 3 && inject_raw) begin
                cmd_req_i = 1'b1; cmd_cs_i = 2'd1; cmd_cmd_i = 3'b010;
            end
            if (c == 4) cmd_req_i = 1'b0;
            if (c == 3 && drop_mode) cmd_mode_i = 1'b0;
        end
        check(n_got == n_exp, "R4", "command count", n_got, n_exp);
        check(bad_idle == 0, "R6", "idle pattern / MRS code", bad_idle, 0);
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            check(got_cyc[i] == exp_cyc[i], (i == 0) ? "R7" : "R6", "command cycle",
                  got_cyc[i], exp_cyc[i]);
            check(got_reg[i] == exp_reg[i], "R3", "register order", got_reg[i], exp_reg[i]);
            check(got_rank[i] == exp_rank[i], "R3", "rank order", got_rank[i], exp_rank[i]);
            check(got_addr[i] == int'(mrv(exp_reg[i], exp_rank[i])), "R5", "mode value",
                  got_addr[i], int'(mrv(exp_reg[i], exp_rank[i])));
        end
        begin
            int dexp;
            dexp = (n_exp == 0) ? 2 : exp_cyc[n_exp-1] + 1;
            check(done_cyc == dexp, "R8", "done cycle", done_cyc, dexp);
            if (drop_mode)
                check(low_cyc == dexp + 1, "R2", "status drop after burst", low_cyc, dexp + 1);
        end
    endtask

    task automatic t_raw();
        cmd_cs_i = 2'd2; cmd_cmd_i = 3'b101; cmd_ba_i = 3'd5; cmd_a_i = 16'h1234;
        cmd_req_i = 1'b1;
        @(negedge clk);
        cmd_req_i = 1'b0;
        check(dram_cs_n_o == 4'b1011, "R9", "raw cs_n", dram_cs_n_o, 4'b1011);
        check({dram_ras_n_o, dram_cas_n_o, dram_we_n_o} == 3'b101, "R9", "raw code",
              {dram_ras_n_o, dram_cas_n_o, dram_we_n_o}, 3'b101);
        check(dram_ba_o == 3'd5 && dram_addr_o == 16'h1234, "R9", "raw bank/addr",
              dram_addr_o, 16'h1234);
        @(negedge clk);
        check(bus_idle(), "R9", "bus idle after raw", dram_cs_n_o, 4'hF);
    endtask

    task automatic t_exit_and_ignore();
        int hits;
        logic done_before;
        cmd_mode_i = 1'b0;
        @(negedge clk);
        check(status_cmd_o == 1'b0, "R2", "status after exit", status_cmd_o, 0);
        done_before = mrs_done_o;
        cs_en_i = 4'hF;
        cmd_req_i = 1'b1; mrs_req_i = 1'b1;
        @(negedge clk);
        cmd_req_i = 1'b0; mrs_req_i = 1'b0;
        hits = 0;
        for (int c = 1; c <= 8; c++) begin
            if (!(&dram_cs_n_o)) hits++;
            if (c < 8) @(negedge clk);
        end
        check(hits == 0, "R10", "requests outside mode", hits, 0);
        check(mrs_done_o == done_before, "R10", "done untouched outside mode",
              mrs_done_o, done_before);
    endtask

    task automatic t_simultaneous();
        int hits; int done_c;
        hits = 0; done_c = -1;
        cs_en_i = 4'h0;
        cmd_cs_i = 2'd3; cmd_cmd_i = 3'b000;
        cmd_req_i = 1'b1; mrs_req_i = 1'b1;
        for (int c = 1; c <= 4; c++) begin
            @(negedge clk);
            cmd_req_i = 1'b0; mrs_req_i = 1'b0;
            if (!(&dram_cs_n_o)) hits++;
            if (mrs_done_o && done_c < 0) done_c = c;
        end
        check(hits == 0, "R10", "raw loses to burst", hits, 0);
        check(done_c == 2, "R8", "empty-mask done cycle", done_c, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_enter();
        t_burst(4'hF, 4, 1'b1, 1'b0);   // full walk, raw request inside burst ignored
        t_burst(4'b0101, 3, 1'b0, 1'b0); // skipped ranks
        t_burst(4'b1000, 0, 1'b0, 1'b0); // gap clamp
        t_burst(4'h0, 4, 1'b0, 1'b0);    // empty mask
        t_raw();
        t_burst(4'b0110, 5, 1'b0, 1'b1); // exit requested mid-burst
        t_enter();
        t_simultaneous();
        t_exit_and_ignore();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule